// File: doc/BRIEF.md
# Dual-channel edge counter

This block keeps a 16-bit signed count that is moved up or down by edges on two input channels. Each channel supplies a pulse input, whose rising and falling edges are the counting events, and a control level that modifies how those events are interpreted. For every channel, an action code for the rising edge and another for the falling edge choose increment, decrement or no change. A modifier code for the control-high state and another for the control-low state then keep that choice, reverse its direction, or suppress it. The pulse and control inputs are assumed to be synchronous and already free of glitches.

Both channels are summed, so a cycle with events on both channels applies the net change in a single update. Two programmable signed limits bound the count. When the next value would equal either limit, the counter loads zero instead and raises a one-cycle limit indication. A sign flag beside that indication tells which limit was reached. A synchronous clear and a pause control give the surrounding logic direct control over the count. Typical uses are quadrature position tracking, gated event counting and direction-aware tachometers.

Top module: `edge_counter`

## Requirements
- R1: After reset, count_o is 0, lim_hit_o is 0 and lim_neg_o is 0; each pulse input's previous-cycle sample is reset to 0.
- R2: An edge is detected by comparing pulse_i[c] with its value at the previous clock: 0 then 1 is rising, 1 then 0 is falling. The count changes at the same clock edge that first samples the new level. A pulse level held unchanged causes no count change.
- R3: Per channel, the 2-bit action code (rise_act_i[c] for rising edges, fall_act_i[c] for falling edges) has these values: 0 means no change, 1 means +1, 2 means -1, and 3 means no change.
- R4: The modifier applied to an edge is hi_mod_i[c] when ctrl_i[c] is 1 and lo_mod_i[c] when ctrl_i[c] is 0. Its values are: 0 keeps the action, 1 swaps +1 and -1, and 2 or 3 inhibits the change.
- R5: The contributions of both channels in one cycle are added and applied as a single net change in the range -2 to +2.
- R6: If the count plus a non-zero net change equals hi_lim_i, compared as signed values before any wrap, the count loads 0 and lim_hit_o is 1 for that cycle with lim_neg_o = 0. The high limit is tested first.
- R7: Otherwise, if that next value equals lo_lim_i, the count loads 0 and lim_hit_o is 1 with lim_neg_o = 1.
- R8: While pause_i is 1, the count holds and lim_hit_o stays 0. Edges that occur during pause are lost, and releasing pause with an unchanged pulse level does not count.
- R9: clear_i forces the count to 0 on the next clock with lim_hit_o = 0. Clear has priority over pause, over counting and over limit detection.
- R10: A next value that matches no limit wraps in two's complement (32766 + 2 gives -32768).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pulse_i | input | NCH | Pulse input per channel |
| ctrl_i | input | NCH | Control level per channel |
| rise_act_i | input | NCH x 2 | Rising-edge action code per channel |
| fall_act_i | input | NCH x 2 | Falling-edge action code per channel |
| hi_mod_i | input | NCH x 2 | Modifier used while control is high |
| lo_mod_i | input | NCH x 2 | Modifier used while control is low |
| hi_lim_i | input | W | Signed high limit |
| lo_lim_i | input | W | Signed low limit |
| pause_i | input | 1 | Hold the count |
| clear_i | input | 1 | Synchronous clear of the count |
| count_o | output | W | Signed count value |
| lim_hit_o | output | 1 | One-cycle pulse: a limit was reached and the count reloaded to 0 |
| lim_neg_o | output | 1 | With lim_hit_o: 1 means the low limit, 0 means the high limit |

## Verification
The bench sweeps every combination of the two action codes, both modifier codes and the control level for a rising and a falling edge. A design that mixed up the edge polarity, read the modifier for the wrong level, or treated the reserved code 3 as active would therefore drift from the arithmetic model. All nine pairs of per-channel directions are applied in the same cycle, which catches a design that drops one channel or applies the two changes serially. Counting to +10 and to -10 checks the reload to zero, the one-cycle hit pulse and its sign flag. A long run up to the positive end of the range shows whether the design wraps or falsely matches a limit through truncation. The pause and clear checks include an edge lost during pause, and a clear that coincides with a would-be limit hit; a design with the wrong priority would count, or would raise a spurious hit.

// File: rtl/edge_counter_pkg.sv
package edge_counter_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DOWN = 2'd2,
    ACT_RSVD = 2'd3
  } edge_act_e;

  typedef enum logic [1:0] {
    MOD_KEEP = 2'd0,
    MOD_FLIP = 2'd1,
    MOD_HOLD = 2'd2,
    MOD_RSVD = 2'd3
  } ctrl_mod_e;
endpackage

// File: rtl/edge_chan.sv
module edge_chan
  import edge_counter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              ctrl_i,
  input  logic [1:0]        rise_act_i,
  input  logic [1:0]        fall_act_i,
  input  logic [1:0]        hi_mod_i,
  input  logic [1:0]        lo_mod_i,
  output logic signed [1:0] step_o
);
  logic      prev_q;
  logic      rise, fall;
  edge_act_e act;
  ctrl_mod_e mode;
  logic signed [1:0] base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pulse_i;
  end

  assign rise = pulse_i & ~prev_q;
  assign fall = ~pulse_i & prev_q;

  always_comb begin
    if (rise)      act = edge_act_e'(rise_act_i);
    else if (fall) act = edge_act_e'(fall_act_i);
    else           act = ACT_NONE;

    case (act)
      ACT_UP:   base = 2'sd1;
      ACT_DOWN: base = -2'sd1;
      default:  base = 2'sd0;
    endcase

    mode = ctrl_i ? ctrl_mod_e'(hi_mod_i) : ctrl_mod_e'(lo_mod_i);
    case (mode)
      MOD_KEEP: step_o = base;
      MOD_FLIP: step_o = -base;
      default:  step_o = 2'sd0;
    endcase
  end
endmodule

// File: rtl/cnt_core.sv
module cnt_core #(
  parameter int W  = 16,
  parameter int DW = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] delta_i,
  input  logic                 pause_i,
  input  logic                 clear_i,
  input  logic        [W-1:0]  hi_lim_i,
  input  logic        [W-1:0]  lo_lim_i,
  output logic        [W-1:0]  count_o,
  output logic                 lim_hit_o,
  output logic                 lim_neg_o
);
  localparam int W1 = W + 1;

  logic signed [W1-1:0] nxt, hi_ext, lo_ext;
  logic        [W-1:0]  count_q;
  logic                 hit_q, neg_q;

  // compare one bit wider than the count so wrap never aliases a limit
  assign nxt    = $signed({count_q[W-1], count_q}) + W1'(delta_i);
  assign hi_ext = $signed({hi_lim_i[W-1], hi_lim_i});
  assign lo_ext = $signed({lo_lim_i[W-1], lo_lim_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      hit_q   <= 1'b0;
      neg_q   <= 1'b0;
    end else if (clear_i) begin
      count_q <= '0;
      hit_q   <= 1'b0;
      neg_q   <= 1'b0;
    end else if (pause_i || delta_i == '0) begin
      hit_q   <= 1'b0;
      neg_q   <= 1'b0;
    end else if (nxt == hi_ext) begin
      count_q <= '0;
      hit_q   <= 1'b1;
      neg_q   <= 1'b0;
    end else if (nxt == lo_ext) begin
      count_q <= '0;
      hit_q   <= 1'b1;
      neg_q   <= 1'b1;
    end else begin
      count_q <= nxt[W-1:0];
      hit_q   <= 1'b0;
      neg_q   <= 1'b0;
    end
  end

  assign count_o   = count_q;
  assign lim_hit_o = hit_q;
  assign lim_neg_o = neg_q;
endmodule

// File: rtl/edge_counter.sv
module edge_counter #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        pulse_i,
  input  logic [NCH-1:0]        ctrl_i,
  input  logic [NCH-1:0][1:0]   rise_act_i,
  input  logic [NCH-1:0][1:0]   fall_act_i,
  input  logic [NCH-1:0][1:0]   hi_mod_i,
  input  logic [NCH-1:0][1:0]   lo_mod_i,
  input  logic [W-1:0]          hi_lim_i,
  input  logic [W-1:0]          lo_lim_i,
  input  logic                  pause_i,
  input  logic                  clear_i,
  output logic [W-1:0]          count_o,
  output logic                  lim_hit_o,
  output logic                  lim_neg_o
);
  localparam int DW = $clog2(NCH + 1) + 1;

  logic signed [1:0]    step [NCH];
  logic signed [DW-1:0] delta;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    edge_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pulse_i    (pulse_i[c]),
      .ctrl_i     (ctrl_i[c]),
      .rise_act_i (rise_act_i[c]),
      .fall_act_i (fall_act_i[c]),
      .hi_mod_i   (hi_mod_i[c]),
      .lo_mod_i   (lo_mod_i[c]),
      .step_o     (step[c])
    );
  end

  // net change of all channels, applied as one update
  always_comb begin
    delta = '0;
    for (int c = 0; c < NCH; c++) delta = delta + DW'(step[c]);
  end

  cnt_core #(.W(W), .DW(DW)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .delta_i   (delta),
    .pause_i   (pause_i),
    .clear_i   (clear_i),
    .hi_lim_i  (hi_lim_i),
    .lo_lim_i  (lo_lim_i),
    .count_o   (count_o),
    .lim_hit_o (lim_hit_o),
    .lim_neg_o (lim_neg_o)
  );
endmodule

// File: rtl/edge_counter_chk.sv
module edge_counter_chk #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         pause_i,
  input logic         clear_i,
  input logic [W-1:0] count_o,
  input logic         lim_hit_o,
  input logic         lim_neg_o
);
  logic [W-1:0] prev_q;
  logic signed [W-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= count_o;
  end

  assign diff = $signed(count_o - prev_q);

  a_r9_clear_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0) && !lim_hit_o);

  a_r8_pause_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_i && !clear_i) |=> $stable(count_o) && !lim_hit_o);

  a_r6_hit_reload : assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_hit_o |-> count_o == '0);

  a_r7_sign_with_hit : assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_neg_o |-> lim_hit_o);

  a_r5_net_step : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !pause_i) |=> lim_hit_o || ((diff <= NCH) && (diff >= -NCH)));
endmodule

bind edge_counter edge_counter_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pause_i   (pause_i),
  .clear_i   (clear_i),
  .count_o   (count_o),
  .lim_hit_o (lim_hit_o),
  .lim_neg_o (lim_neg_o)
);

// File: tb/edge_counter_tb.sv
module edge_counter_tb;
  localparam int W   = 16;
  localparam int NCH = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                  rst_ni;
  logic [NCH-1:0]        pulse, ctrl;
  logic [NCH-1:0][1:0]   ract, fact, hmod, lmod;
  logic signed [W-1:0]   hlim, llim;
  logic                  pause, clr;
  logic [W-1:0]          cnt;
  logic                  hit, neg;

  int n_run = 0, n_fail = 0;
  int exp_cnt = 0;
  bit exp_hit = 0, exp_neg = 0;

  edge_counter #(.W(W), .NCH(NCH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pulse_i(pulse), .ctrl_i(ctrl),
    .rise_act_i(ract), .fall_act_i(fact), .hi_mod_i(hmod), .lo_mod_i(lmod),
    .hi_lim_i(hlim), .lo_lim_i(llim), .pause_i(pause), .clear_i(clr),
    .count_o(cnt), .lim_hit_o(hit), .lim_neg_o(neg)
  );

  function automatic int dirn(int act, int m);
    int b;
    b = (act == 1) ? 1 : (act == 2) ? -1 : 0;
    if (m == 1) b = -b;
    else if (m >= 2) b = 0;
    return b;
  endfunction

  task automatic check(string tag);
    int got;
    got = int'($signed(cnt));
    n_run++;
    if (got != exp_cnt || hit != exp_hit || neg != exp_neg) begin
      n_fail++;
      $display("FAIL %s: count=%0d exp=%0d hit=%0b exp=%0b neg=%0b exp=%0b",
               tag, got, exp_cnt, hit, exp_hit, neg, exp_neg);
    end
  endtask

  // called just after a negedge: apply new pulse levels, model, check one cycle later
  task automatic drive(logic [NCH-1:0] newp, string tag);
    int sum, nx;
    sum = 0;
    for (int c = 0; c < NCH; c++) begin
      int m;
      m = ctrl[c] ? int'(hmod[c]) : int'(lmod[c]);
      if (newp[c] && !pulse[c]) sum += dirn(int'(ract[c]), m);
      if (!newp[c] && pulse[c]) sum += dirn(int'(fact[c]), m);
    end
    pulse = newp;
    exp_hit = 0; exp_neg = 0;
    if (clr) exp_cnt = 0;
    else if (!pause && sum != 0) begin
      nx = exp_cnt + sum;
      if (nx == int'(hlim)) begin exp_cnt = 0; exp_hit = 1; end
      else if (nx == int'(llim)) begin exp_cnt = 0; exp_hit = 1; exp_neg = 1; end
      else begin
        if (nx > 32767) nx -= 65536;
        if (nx < -32768) nx += 65536;
        exp_cnt = nx;
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    drive(pulse, "R9 clear");
    clr = 1'b0;
  endtask

  task automatic cfg(int c, int ra, int fa, int hm, int lm);
    ract[c] = 2'(ra); fact[c] = 2'(fa); hmod[c] = 2'(hm); lmod[c] = 2'(lm);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pulse = '0; ctrl = '0; ract = '0; fact = '0; hmod = '0; lmod = '0;
    hlim = 16'sd100; llim = -16'sd100; pause = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    exp_cnt = 0; exp_hit = 0; exp_neg = 0;
    check("R1 reset");

    // R3 R4: sweep every code on channel 0 with channel 1 idle
    for (int ra = 0; ra < 4; ra++)
      for (int fa = 0; fa < 4; fa++)
        for (int hm = 0; hm < 4; hm++)
          for (int lm = 0; lm < 4; lm++)
            for (int lv = 0; lv < 2; lv++) begin
              do_clear();
              cfg(0, ra, fa, hm, lm);
              cfg(1, 0, 0, 0, 0);
              ctrl[0] = lv[0];
              drive({pulse[1], 1'b1}, "R3 R4 rising");
              drive({pulse[1], 1'b1}, "R2 held high");
              drive({pulse[1], 1'b0}, "R3 R4 falling");
            end

    // R5: simultaneous edges on both channels, all direction pairs
    ctrl = '1;
    for (int d0 = -1; d0 <= 1; d0++)
      for (int d1 = -1; d1 <= 1; d1++) begin
        do_clear();
        cfg(0, d0 > 0 ? 1 : d0 < 0 ? 2 : 0, d0 > 0 ? 1 : d0 < 0 ? 2 : 0, 0, 0);
        cfg(1, d1 > 0 ? 1 : d1 < 0 ? 2 : 0, d1 > 0 ? 1 : d1 < 0 ? 2 : 0, 0, 0);
        drive(~pulse, "R5 both rise");
        drive(~pulse, "R5 both fall");
      end

    // R6: reach +10
    hlim = 16'sd10; llim = -16'sd10;
    do_clear();
    cfg(0, 1, 1, 0, 0); cfg(1, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) drive({pulse[1], ~pulse[0]}, "R6 high limit");

    // R7: reach -10
    do_clear();
    cfg(0, 2, 2, 0, 0);
    for (int i = 0; i < 12; i++) drive({pulse[1], ~pulse[0]}, "R7 low limit");

    // R8: pause freezes, lost edge not replayed
    do_clear();
    cfg(0, 1, 1, 0, 0);
    drive({pulse[1], ~pulse[0]}, "R8 pre-pause");
    pause = 1'b1;
    drive({pulse[1], ~pulse[0]}, "R8 paused edge");
    drive({pulse[1], ~pulse[0]}, "R8 paused edge");
    drive({pulse[1], ~pulse[0]}, "R8 paused edge");
    pause = 1'b0;
    drive(pulse, "R8 release no edge");
    drive({pulse[1], ~pulse[0]}, "R8 resumed");

    // R9: clear beats pause and a would-be limit hit
    for (int i = 0; i < 7; i++) drive({pulse[1], ~pulse[0]}, "R9 setup");
    pause = 1'b1; clr = 1'b1;
    drive({pulse[1], ~pulse[0]}, "R9 clear over pause");
    pause = 1'b0; clr = 1'b0;
    for (int i = 0; i < 9; i++) drive({pulse[1], ~pulse[0]}, "R9 setup");
    clr = 1'b1;
    drive({pulse[1], ~pulse[0]}, "R9 clear over limit");
    clr = 1'b0;

    // R10: +2 per cycle up to the top of the range and wrap
    hlim = 16'sd1; llim = 16'sd1;
    cfg(0, 1, 1, 0, 0); cfg(1, 1, 1, 0, 0);
    do_clear();
    for (int i = 0; i < 16384; i++) drive(~pulse, "R10 wrap run");
    n_run++;
    if (exp_cnt != -32768) begin
      n_fail++;
      $display("FAIL R10 end value: model=%0d exp=-32768", exp_cnt);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule